// File: doc/BRIEF.md
# APB down-counting timer

A single-channel 32-bit timer that counts down on every clock while enabled and sits behind an APB slave register interface. Software sets a load count and a control word. In periodic mode the counter reloads the load count each time it reaches zero. In free-running mode it wraps to all ones instead. Every expiry sets a pending interrupt flag. A mask bit gates that flag onto the interrupt output, and reading either of two end-of-interrupt addresses clears it.

The counter is governed by a two-state machine. `ST_OFF` holds the count and raises no expiry. Transition *arm* (`ST_OFF` to `ST_RUN`) happens on the first clock on which the enable bit is seen set, and it copies the load count into the counter. In `ST_RUN`, transition *step* (stay in `ST_RUN`) decrements the counter or, at zero, performs an *expire*: it reloads the load count in periodic mode or all ones in free-running mode, and it sets the pending flag. Transition *halt* (`ST_RUN` to `ST_OFF`) happens on the first clock on which the enable bit is seen clear.

Top module: `apb_dtimer`

## Requirements
- R1: After reset, the load count, control, current value and raw status registers read 0, and the interrupt output is low.
- R2: The clock after a write that sets enable (control bit 0) while the timer is off, the counter holds the load count. Each later re-enable loads the load count again.
- R3: While enabled, the counter decrements by one per clock. After enable is cleared, the counter holds its value and no expiry occurs.
- R4: In periodic mode (control bit 1 = 1), the clock after the count is zero reloads the load count and sets the raw flag. The period is therefore load count + 1 clocks.
- R5: In free-running mode (control bit 1 = 0), the clock after the count is zero loads 0xFFFFFFFF and sets the raw flag.
- R6: With the mask (control bit 2 = 1), the interrupt output and the masked status read 0 while the raw status still sets. Clearing the mask with a flag pending drives the output high.
- R7: A read of 0x0C or 0xA4 returns 0 and clears the pending flag. It changes no other register.
- R8: If an expiry and an end-of-interrupt read fall on the same clock, the flag stays set.
- R9: 0xAC reads the VERSION parameter. Unmapped addresses read 0. Writes to read-only or unmapped addresses change nothing. PREADY is always 1.
- R10: The register map is as follows. 0x00 is the read/write load count and 0x04 is the live count. 0x08 is control, bits [2:0] only. 0x10 and 0xA0 give the masked status in bit 0, and 0xA8 gives the raw status in bit 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pclk | input | 1 | Bus and counter clock |
| presetn | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 write, 0 read |
| paddr | input | ADDR_W | Byte address |
| pwdata | input | DATA_W | Write data |
| prdata | output | DATA_W | Read data |
| pready | output | 1 | Transfer ready, tied high |
| timer_irq | output | 1 | Masked interrupt, level |

## Verification
Each kind of internal fault shows up at the ports within a few clocks.
- A counter that skips the *arm* load or decrements at the wrong rate returns the wrong value on the first read of the current-value register after enabling.
- A wrong reload value in the *expire* transition shifts the time of the next interrupt edge by whole clocks. The bench measures that time exactly, so a shift of one clock is caught.
- A flag that clears when it should be set, or is set with no expiry, shows on `timer_irq` at the edge right after the end-of-interrupt read that collides with an expiry.
- A wrong mask path shows as a difference between the raw and masked status reads on the same pending flag.

// File: rtl/timer_pkg.sv
`timescale 1ns/1ps
package timer_pkg;

    typedef enum logic {
        ST_OFF = 1'b0,
        ST_RUN = 1'b1
    } cnt_state_e;

    localparam logic [7:0] OFS_LOAD  = 8'h00;
    localparam logic [7:0] OFS_CUR   = 8'h04;
    localparam logic [7:0] OFS_CTL   = 8'h08;
    localparam logic [7:0] OFS_EOI   = 8'h0C;
    localparam logic [7:0] OFS_STAT  = 8'h10;
    localparam logic [7:0] OFS_GSTAT = 8'hA0;
    localparam logic [7:0] OFS_GEOI  = 8'hA4;
    localparam logic [7:0] OFS_RAW   = 8'hA8;
    localparam logic [7:0] OFS_VER   = 8'hAC;

    localparam int CTL_EN_BIT   = 0;
    localparam int CTL_PER_BIT  = 1;
    localparam int CTL_MASK_BIT = 2;

endpackage

// File: rtl/timer_regs.sv
`timescale 1ns/1ps
module timer_regs
    import timer_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter logic [DATA_W-1:0] VERSION = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    input  logic [DATA_W-1:0] count,
    input  logic              raw_flag,
    input  logic              masked_flag,
    output logic [DATA_W-1:0] prdata,
    output logic [DATA_W-1:0] load_val,
    output logic              ctl_en,
    output logic              ctl_per,
    output logic              ctl_mask,
    output logic              eoi_pulse
);

    localparam int PAD_W = DATA_W - 3;

    logic acc_wr;
    logic acc_rd;

    assign acc_wr = psel && penable && pwrite;
    assign acc_rd = psel && penable && !pwrite;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            load_val <= '0;
            ctl_en   <= 1'b0;
            ctl_per  <= 1'b0;
            ctl_mask <= 1'b0;
        end else if (acc_wr) begin
            if (paddr == ADDR_W'(OFS_LOAD)) begin
                load_val <= pwdata;
            end
            if (paddr == ADDR_W'(OFS_CTL)) begin
                ctl_en   <= pwdata[CTL_EN_BIT];
                ctl_per  <= pwdata[CTL_PER_BIT];
                ctl_mask <= pwdata[CTL_MASK_BIT];
            end
        end
    end

    assign eoi_pulse = acc_rd &&
                       ((paddr == ADDR_W'(OFS_EOI)) || (paddr == ADDR_W'(OFS_GEOI)));

    always_comb begin
        prdata = '0;
        case (paddr)
            ADDR_W'(OFS_LOAD):  prdata = load_val;
            ADDR_W'(OFS_CUR):   prdata = count;
            ADDR_W'(OFS_CTL):   prdata = {{PAD_W{1'b0}}, ctl_mask, ctl_per, ctl_en};
            ADDR_W'(OFS_STAT):  prdata = DATA_W'(masked_flag);
            ADDR_W'(OFS_GSTAT): prdata = DATA_W'(masked_flag);
            ADDR_W'(OFS_RAW):   prdata = DATA_W'(raw_flag);
            ADDR_W'(OFS_VER):   prdata = VERSION;
            default:            prdata = '0;
        endcase
    end

    AST_CTL_ONLY_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_wr && paddr == ADDR_W'(OFS_CTL)) |=> $stable({ctl_en, ctl_per, ctl_mask})) // R9
        else $error("control changed without a control write");

endmodule

// File: rtl/timer_counter.sv
`timescale 1ns/1ps
module timer_counter
    import timer_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              periodic,
    input  logic [DATA_W-1:0] load_val,
    output logic [DATA_W-1:0] count,
    output logic              expire
);

    cnt_state_e state_q;
    cnt_state_e state_d;
    logic       at_zero;

    assign at_zero = (count == '0);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: if (en)  state_d = ST_RUN;
            ST_RUN: if (!en) state_d = ST_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else begin
            unique case (state_q)
                ST_OFF: begin
                    if (en) count <= load_val;
                end
                ST_RUN: begin
                    if (en) begin
                        if (at_zero) count <= periodic ? load_val : '1;
                        else         count <= count - 1'b1;
                    end
                end
            endcase
        end
    end

    assign expire = (state_q == ST_RUN) && en && at_zero;

    AST_LOAD_ON_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OFF && en) |=> (count == $past(load_val))) // R2
        else $error("arm did not load the load count");

    AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!en) |=> $stable(count)) // R3
        else $error("count moved while disabled");

    AST_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && en && !at_zero) |=> (count == $past(count) - 1'b1)) // R3
        else $error("count did not step down by one");

    AST_PERIODIC_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && periodic) |=> (count == $past(load_val))) // R4
        else $error("periodic reload wrong");

    AST_FREE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !periodic) |=> (count == '1)) // R5
        else $error("free-running wrap wrong");

endmodule

// File: rtl/timer_irq.sv
`timescale 1ns/1ps
module timer_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic expire,
    input  logic eoi,
    input  logic mask,
    output logic raw_flag,
    output logic irq
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      raw_flag <= 1'b0;
        else if (expire) raw_flag <= 1'b1;
        else if (eoi)    raw_flag <= 1'b0;
    end

    assign irq = raw_flag && !mask;

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> raw_flag) // R8
        else $error("expiry lost");

    AST_EOI_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi && !expire) |=> !raw_flag) // R7
        else $error("end-of-interrupt did not clear");

    AST_RAW_NEEDS_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(raw_flag) |-> $past(expire)) // R4
        else $error("flag set without expiry");

endmodule

// File: rtl/apb_dtimer.sv
`timescale 1ns/1ps
module apb_dtimer #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter logic [DATA_W-1:0] VERSION = 32'h3230_312A
) (
    input  logic              pclk,
    input  logic              presetn,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    output logic [DATA_W-1:0] prdata,
    output logic              pready,
    output logic              timer_irq
);

    logic [DATA_W-1:0] load_val;
    logic [DATA_W-1:0] count;
    logic              ctl_en;
    logic              ctl_per;
    logic              ctl_mask;
    logic              eoi_pulse;
    logic              expire;
    logic              raw_flag;
    logic              irq_int;

    assign pready    = 1'b1;
    assign timer_irq = irq_int;

    timer_regs #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .VERSION (VERSION)
    ) u_regs (
        .clk         (pclk),
        .rst_n       (presetn),
        .psel        (psel),
        .penable     (penable),
        .pwrite      (pwrite),
        .paddr       (paddr),
        .pwdata      (pwdata),
        .count       (count),
        .raw_flag    (raw_flag),
        .masked_flag (irq_int),
        .prdata      (prdata),
        .load_val    (load_val),
        .ctl_en      (ctl_en),
        .ctl_per     (ctl_per),
        .ctl_mask    (ctl_mask),
        .eoi_pulse   (eoi_pulse)
    );

    timer_counter #(
        .DATA_W (DATA_W)
    ) u_counter (
        .clk      (pclk),
        .rst_n    (presetn),
        .en       (ctl_en),
        .periodic (ctl_per),
        .load_val (load_val),
        .count    (count),
        .expire   (expire)
    );

    timer_irq u_irq (
        .clk      (pclk),
        .rst_n    (presetn),
        .expire   (expire),
        .eoi      (eoi_pulse),
        .mask     (ctl_mask),
        .raw_flag (raw_flag),
        .irq      (irq_int)
    );

    AST_MASKED_QUIET: assert property (@(posedge pclk) disable iff (!presetn)
        $past(ctl_mask) && ctl_mask |-> !timer_irq) // R6
        else $error("interrupt while masked");

endmodule

// File: tb/apb_dtimer_bench.sv
`timescale 1ns/1ps
module apb_dtimer_bench;

    localparam logic [31:0] EXP_VER = 32'h5A17_0C03;

    logic        pclk = 1'b0;
    logic        presetn = 1'b0;
    logic        psel = 1'b0;
    logic        penable = 1'b0;
    logic        pwrite = 1'b0;
    logic [7:0]  paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        pready;
    logic        timer_irq;

    int n_chk = 0;
    int n_bad = 0;

    always #10 pclk = ~pclk;

    apb_dtimer #(.ADDR_W(8), .DATA_W(32), .VERSION(EXP_VER)) u_apb_dtimer (
        .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .pready(pready), .timer_irq(timer_irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic apb_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge pclk);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d;
        @(negedge pclk);
        penable = 1'b1;
        @(negedge pclk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic apb_rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge pclk);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a;
        @(negedge pclk);
        penable = 1'b1;
        #1;
        d = prdata;
        chk("R9 pready", {31'b0, pready}, 32'd1);
        @(negedge pclk);
        psel = 1'b0; penable = 1'b0;
    endtask

    task automatic wait_irq(output int j);
        j = 0;
        while (!timer_irq && j < 200) begin
            @(negedge pclk);
            j++;
        end
    endtask

    task automatic t_reset();
        logic [31:0] v;
        chk("R1 irq", {31'b0, timer_irq}, 32'd0);
        apb_rd(8'h00, v); chk("R1 load", v, 32'd0);
        apb_rd(8'h08, v); chk("R1 control", v, 32'd0);
        apb_rd(8'h04, v); chk("R1 current", v, 32'd0);
        apb_rd(8'hA8, v); chk("R1 raw", v, 32'd0);
    endtask

    task automatic t_regmap();
        logic [31:0] v;
        apb_wr(8'h00, 32'h1234_5678);
        apb_rd(8'h00, v); chk("R10 load readback", v, 32'h1234_5678);
        apb_wr(8'h08, 32'hFFFF_FFFE);
        apb_rd(8'h08, v); chk("R10 control bits", v, 32'd6);
        apb_wr(8'h08, 32'd0);
    endtask

    task automatic t_enable_load();
        logic [31:0] v;
        apb_wr(8'h00, 32'd100);
        apb_wr(8'h08, 32'd1);
        apb_rd(8'h04, v); chk("R2 first enable", v, 32'd99);
        apb_wr(8'h08, 32'd0);
        apb_wr(8'h00, 32'd50);
        apb_wr(8'h08, 32'd1);
        apb_rd(8'h04, v); chk("R2 re-enable", v, 32'd49);
        apb_wr(8'h08, 32'd0);
    endtask

    task automatic t_hold();
        logic [31:0] v;
        apb_wr(8'h00, 32'd10);
        apb_wr(8'h08, 32'd1);
        apb_wr(8'h08, 32'd0);
        apb_rd(8'h04, v); chk("R3 decrement then stop", v, 32'd8);
        repeat (20) @(negedge pclk);
        apb_rd(8'h04, v); chk("R3 hold", v, 32'd8);
        apb_rd(8'hA8, v); chk("R3 no expiry when off", v, 32'd0);
        chk("R3 irq off", {31'b0, timer_irq}, 32'd0);
    endtask

    task automatic t_misc();
        logic [31:0] v;
        apb_wr(8'h04, 32'hDEAD_BEEF);
        apb_rd(8'h04, v); chk("R9 current write ignored", v, 32'd8);
        apb_wr(8'hA8, 32'd1);
        apb_rd(8'hA8, v); chk("R9 raw write ignored", v, 32'd0);
        apb_wr(8'h40, 32'hFFFF_FFFF);
        apb_rd(8'h00, v); chk("R9 unmapped write ignored", v, 32'd10);
        apb_rd(8'hAC, v); chk("R9 version", v, EXP_VER);
        apb_rd(8'h40, v); chk("R9 unmapped read", v, 32'd0);
        apb_rd(8'hFC, v); chk("R9 unmapped read high", v, 32'd0);
    endtask

    task automatic t_periodic();
        logic [31:0] v;
        int j;
        apb_wr(8'h00, 32'd5);
        apb_wr(8'h08, 32'd3);
        wait_irq(j); chk("R4 first expiry time", j, 32'd7);
        apb_rd(8'h0C, v); chk("R7 eoi reads zero", v, 32'd0);
        chk("R7 eoi clears", {31'b0, timer_irq}, 32'd0);
        wait_irq(j); chk("R4 period", j, 32'd3);
        apb_rd(8'h10, v); chk("R10 masked status", v, 32'd1);
        apb_rd(8'hA4, v);
        chk("R8 expiry beats eoi", {31'b0, timer_irq}, 32'd1);
        apb_rd(8'hA4, v);
        chk("R7 global eoi clears", {31'b0, timer_irq}, 32'd0);
        apb_wr(8'h08, 32'd0);
        apb_rd(8'h0C, v);
    endtask

    task automatic t_free_mask();
        logic [31:0] v;
        apb_wr(8'h00, 32'd2);
        apb_wr(8'h08, 32'd5);
        repeat (3) @(negedge pclk);
        apb_rd(8'h04, v); chk("R5 wrap to all ones", v, 32'hFFFF_FFFE);
        chk("R6 irq masked", {31'b0, timer_irq}, 32'd0);
        apb_rd(8'hA8, v); chk("R6 raw sets", v, 32'd1);
        apb_rd(8'hA0, v); chk("R6 global masked status", v, 32'd0);
        apb_rd(8'h10, v); chk("R6 channel masked status", v, 32'd0);
        apb_wr(8'h08, 32'd1);
        chk("R6 unmask shows pending", {31'b0, timer_irq}, 32'd1);
        apb_rd(8'hA4, v);
        chk("R7 eoi clears free", {31'b0, timer_irq}, 32'd0);
        apb_rd(8'h08, v); chk("R7 control untouched", v, 32'd1);
        apb_rd(8'h00, v); chk("R7 load untouched", v, 32'd2);
    endtask

    initial begin
        repeat (3) @(negedge pclk);
        presetn = 1'b1;
        @(negedge pclk);
        t_reset();
        t_regmap();
        t_enable_load();
        t_hold();
        t_misc();
        t_periodic();
        t_free_mask();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge pclk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule